// File: doc/BRIEF.md
# Halt and Wake-up Sequencer

This block controls the power-down state of a small processor core. A one-cycle halt request puts it into the halted state. While halted, the system clock enable is low and the core is held. On entry it also clears the watchdog and sets the power-down flag. While halted it watches four kinds of wake source. The first is the external reset, which is the block's asynchronous reset. The second is interrupt requests that were not already pending when the halt began. The third is falling edges on port pins that have their wake enable set. The fourth is a watchdog overflow.

When a wake source is seen, the clock enable comes back at once. The core, however, stays held for a fixed dummy period of `DELAY` cycles. At the end of that period the block pulses `wake_done` and drives a two-bit outcome code. The code tells the core to resume at the next instruction, to take the interrupt, or to perform a warm reset. Two status flags, power-down (`pdf`) and time-out (`to`), record how the core last left service. The pair reads 0/0 after power-up, `to`=1 and `pdf`=0 after a time-out in normal running, and both set after a time-out during halt.

Top module: `halt_wake_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pdf`=0, `to`=0, `sys_clk_en`=1, `cpu_hold`=0 and `wake_done`=0.
- R2: A `halt_req` seen while running drives `wdt_clear` high in that same cycle. After the next clock edge, `sys_clk_en`=0, `cpu_hold`=1, `pdf`=1 and `to`=0.
- R3: `wdt_clr` while running (with no halt request and no overflow) drives `wdt_clear` high in that cycle and clears both `pdf` and `to` at the next edge.
- R4: `wdt_ovf` while running (with no halt request) sets `to` at the next edge. It leaves `pdf` unchanged and does not hold the core.
- R5: Each port pin goes through two synchronizing flip-flops before edge detection. Only a falling edge on a pin whose `pin_wake_en` bit is 1 wakes the block. A falling edge on a disabled pin has no effect.
- R6: An interrupt request bit that rises during halt wakes the block. A bit that was already 1 when the halt was entered cannot wake it.
- R7: From the wake event, `sys_clk_en` is 1 while `cpu_hold` stays 1 for exactly `DELAY` cycles. After that, `cpu_hold` falls and `wake_done` pulses for one cycle.
- R8: Outcome codes on `wake_kind` are 2'b01 = resume at the next instruction, 2'b10 = take the interrupt, and 2'b11 = warm reset. An interrupt wake gives 2'b10 when any waking request bit has its `irq_en` bit set and `stack_full`=0. Otherwise it gives 2'b01. A pin wake gives 2'b01.
- R9: A watchdog overflow during halt sets `to`, keeps `pdf`=1 and yields outcome 2'b11.
- R10: When wake sources coincide, a watchdog overflow takes priority over an interrupt, and an interrupt takes priority over a pin.
- R11: During the dummy period, `halt_req`, `wdt_ovf` and all other wake sources are ignored. The period length, the outcome and `to` are unchanged.
- R12: Asserting `rst_n` during halt restores the state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| halt_req | input | 1 | Halt instruction strobe |
| wdt_clr | input | 1 | Watchdog clear command |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| irq_req | input | NIRQ | Interrupt request flags |
| irq_en | input | NIRQ | Interrupt enables |
| stack_full | input | 1 | Return stack has no free entry |
| pin_in | input | NPIN | Port pins, asynchronous |
| pin_wake_en | input | NPIN | Per-pin wake enable |
| sys_clk_en | output | 1 | System clock enable |
| cpu_hold | output | 1 | Core held (halt or dummy period) |
| wdt_clear | output | 1 | Clears watchdog and prescaler |
| pdf | output | 1 | Power-down flag |
| to | output | 1 | Time-out flag |
| wake_done | output | 1 | One-cycle pulse at end of dummy period |
| wake_kind | output | 2 | Wake outcome code |

## Verification
Some properties are checked by assertions on every cycle. The clock enable may only be low while the core is held. Halt entry must set the flags and gate the clock. The clear command and a running overflow must each update the flags. The dummy period length is measured by a counter at every wake. Every completion must carry a valid outcome, and a warm reset must come with `to` set.

Other behaviour can only be shown by the bench scenarios. These cover the decision between resuming and taking the interrupt, the masking of requests that were pending before the halt, the effect of the per-pin enables, the priority between coinciding sources, and the fact that sources are ignored during the dummy period.

// File: rtl/halt_wake_seq.sv
module halt_wake_seq #(
  parameter int NPIN  = 8,
  parameter int NIRQ  = 4,
  parameter int DELAY = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req,
  input  logic            wdt_clr,
  input  logic            wdt_ovf,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            stack_full,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] pin_wake_en,
  output logic            sys_clk_en,
  output logic            cpu_hold,
  output logic            wdt_clear,
  output logic            pdf,
  output logic            to,
  output logic            wake_done,
  output logic [1:0]      wake_kind
);
  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [1:0] K_RESUME = 2'b01;
  localparam logic [1:0] K_INT    = 2'b10;
  localparam logic [1:0] K_WARM   = 2'b11;

  typedef enum logic [1:0] {S_RUN, S_HALT, S_WAKE} st_t;
  st_t state;

  logic [NPIN-1:0] sy1, sy2, sy3;
  logic [NIRQ-1:0] armed;
  logic [CW-1:0]   cnt;

  wire [NPIN-1:0] pin_fall = sy3 & ~sy2 & pin_wake_en;
  wire [NIRQ-1:0] irq_hit  = irq_req & armed;
  wire            irq_take = (|(irq_hit & irq_en)) & ~stack_full;
  wire            wake_any = wdt_ovf | (|irq_hit) | (|pin_fall);
  wire [1:0]      kind_nx  = wdt_ovf ? K_WARM :
                             ((|irq_hit) && irq_take) ? K_INT : K_RESUME;

  assign sys_clk_en = (state != S_HALT);
  assign cpu_hold   = (state != S_RUN);
  assign wdt_clear  = (state == S_RUN) && (halt_req || wdt_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '1;
      sy2 <= '1;
      sy3 <= '1;
    end else begin
      sy1 <= pin_in;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_RUN;
      pdf       <= 1'b0;
      to        <= 1'b0;
      armed     <= '0;
      cnt       <= '0;
      wake_done <= 1'b0;
      wake_kind <= 2'b00;
    end else begin
      wake_done <= 1'b0;
      case (state)
        S_RUN: begin
          if (halt_req) begin
            state <= S_HALT;
            pdf   <= 1'b1;
            to    <= 1'b0;
            armed <= ~irq_req;
          end else if (wdt_ovf) begin
            to <= 1'b1;
          end else if (wdt_clr) begin
            pdf <= 1'b0;
            to  <= 1'b0;
          end
        end
        S_HALT: begin
          if (wake_any) begin
            state     <= S_WAKE;
            cnt       <= CW'(DELAY - 1);
            wake_kind <= kind_nx;
            if (wdt_ovf) to <= 1'b1;
          end
        end
        S_WAKE: begin
          if (cnt == '0) begin
            state     <= S_RUN;
            wake_done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_RUN;
      endcase
    end
  end
endmodule

// File: rtl/halt_wake_seq_chk.sv
module halt_wake_seq_chk #(
  parameter int DELAY = 1024
) (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_req,
  input logic       wdt_clr,
  input logic       wdt_ovf,
  input logic       sys_clk_en,
  input logic       cpu_hold,
  input logic       pdf,
  input logic       to,
  input logic       wake_done,
  input logic [1:0] wake_kind
);
  int hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_cnt <= 0;
    else if (sys_clk_en && cpu_hold) hold_cnt <= hold_cnt + 1;
    else hold_cnt <= 0;
  end

  p_gate_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_clk_en |-> cpu_hold);

  p_halt_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hold && halt_req) |=> (!sys_clk_en && pdf && !to));

  p_clear_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hold && !halt_req && !wdt_ovf && wdt_clr) |=> (!pdf && !to));

  p_run_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hold && !halt_req && wdt_ovf) |=> (to && !cpu_hold && $stable(pdf)));

  p_delay_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (hold_cnt == DELAY));

  p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> $fell(cpu_hold));

  p_kind_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (wake_kind != 2'b00));

  p_warm_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_done && wake_kind == 2'b11) |-> (to && pdf));
endmodule

bind halt_wake_seq halt_wake_seq_chk #(.DELAY(DELAY)) chk_i (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wdt_clr(wdt_clr),
  .wdt_ovf(wdt_ovf), .sys_clk_en(sys_clk_en), .cpu_hold(cpu_hold),
  .pdf(pdf), .to(to), .wake_done(wake_done), .wake_kind(wake_kind)
);

// File: tb/halt_wake_seq_tb_top.sv
module halt_wake_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 8;
  localparam int NIRQ = 4;
  localparam int DLY  = 1024;
  localparam int NVEC = 6;
  // {src[2:0] (0 pin, 1 irq, 2 ovf, 3 irq+ovf), en, stack_full, kind[1:0], to}
  localparam logic [7:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 1'b0, 2'b01, 1'b0},
    {3'd1, 1'b1, 1'b0, 2'b10, 1'b0},
    {3'd1, 1'b1, 1'b1, 2'b01, 1'b0},
    {3'd1, 1'b0, 1'b0, 2'b01, 1'b0},
    {3'd2, 1'b0, 1'b0, 2'b11, 1'b1},
    {3'd3, 1'b1, 1'b0, 2'b11, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, halt_req, wdt_clr, wdt_ovf, stack_full;
  logic [NIRQ-1:0] irq_req, irq_en;
  logic [NPIN-1:0] pin_in, pin_wake_en;
  logic sys_clk_en, cpu_hold, wdt_clear, pdf, to, wake_done;
  logic [1:0] wake_kind;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_wake_seq #(.NPIN(NPIN), .NIRQ(NIRQ), .DELAY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wdt_clr(wdt_clr),
    .wdt_ovf(wdt_ovf), .irq_req(irq_req), .irq_en(irq_en),
    .stack_full(stack_full), .pin_in(pin_in), .pin_wake_en(pin_wake_en),
    .sys_clk_en(sys_clk_en), .cpu_hold(cpu_hold), .wdt_clear(wdt_clear),
    .pdf(pdf), .to(to), .wake_done(wake_done), .wake_kind(wake_kind)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_halt();
    halt_req = 1'b1;
    #1;
    chk("R2 wdt_clear on halt", wdt_clear, 1);
    @(negedge clk);
    halt_req = 1'b0;
    chk("R2 clk_en low", sys_clk_en, 0);
    chk("R2 hold high", cpu_hold, 1);
    chk("R2 pdf set", pdf, 1);
    chk("R2 to cleared", to, 0);
  endtask

  task automatic wait_wake(input string tag, input int pre, input int exp_kind, input int exp_to);
    int cnt = pre;
    bit seen = 0;
    for (int i = 0; i < DLY + 100; i++) begin
      @(negedge clk);
      if (wake_done) begin seen = 1; break; end
      if (sys_clk_en && cpu_hold) cnt++;
    end
    chk({tag, " R7 wake_done seen"}, int'(seen), 1);
    chk({tag, " R7 delay length"}, cnt, DLY);
    chk({tag, " R7 hold released"}, cpu_hold, 0);
    chk({tag, " R8 kind"}, wake_kind, exp_kind);
    chk({tag, " R9 to"}, to, exp_to);
    chk({tag, " pdf kept"}, pdf, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; halt_req = 1'b0; wdt_clr = 1'b0; wdt_ovf = 1'b0;
    stack_full = 1'b0; irq_req = '0; irq_en = '0;
    pin_in = '1; pin_wake_en = 8'h04;
    idle(3);
    chk("R1 pdf in reset", pdf, 0);
    chk("R1 clk_en in reset", sys_clk_en, 1);
    rst_n = 1'b1;
    idle(2);
    chk("R1 pdf", pdf, 0);
    chk("R1 to", to, 0);
    chk("R1 hold", cpu_hold, 0);
    chk("R1 wake_done", wake_done, 0);

    wdt_ovf = 1'b1;
    @(negedge clk);
    wdt_ovf = 1'b0;
    chk("R4 to set", to, 1);
    chk("R4 pdf unchanged", pdf, 0);
    chk("R4 no hold", cpu_hold, 0);

    wdt_clr = 1'b1;
    #1;
    chk("R3 wdt_clear", wdt_clear, 1);
    @(negedge clk);
    wdt_clr = 1'b0;
    chk("R3 to cleared", to, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] src;
      src = VEC[v][7:5];
      irq_en = {2'b00, VEC[v][4], 1'b0};
      stack_full = VEC[v][3];
      do_halt();
      idle(5);
      chk("R2 still halted", sys_clk_en, 0);
      case (src)
        3'd0: pin_in[2] = 1'b0;
        3'd1: irq_req[1] = 1'b1;
        3'd2: wdt_ovf = 1'b1;
        default: begin irq_req[1] = 1'b1; wdt_ovf = 1'b1; end
      endcase
      @(negedge clk);
      wdt_ovf = 1'b0;
      wait_wake($sformatf("vec%0d R10", v), (sys_clk_en && cpu_hold) ? 1 : 0,
                VEC[v][2:1], VEC[v][0]);
      irq_req = '0;
      pin_in = '1;
      idle(5);
    end

    if (to) begin
      wdt_clr = 1'b1;
      @(negedge clk);
      wdt_clr = 1'b0;
      chk("R3 clear after warm", pdf + to, 0);
    end

    // R6: request pending before halt cannot wake
    stack_full = 1'b0;
    irq_en = 4'b0011;
    irq_req = 4'b0001;
    do_halt();
    idle(20);
    chk("R6 pending irq ignored", sys_clk_en, 0);
    irq_req = 4'b0011;
    @(negedge clk);
    wait_wake("R6 new irq", 1, 2, 0);
    irq_req = '0;
    idle(5);

    // R5: disabled pin ignored, enabled pin wakes
    do_halt();
    pin_in[3] = 1'b0;
    idle(10);
    chk("R5 disabled pin ignored", sys_clk_en, 0);
    pin_in[2] = 1'b0;
    wait_wake("R5 enabled pin", 0, 1, 0);
    pin_in = '1;
    idle(5);

    // R11: sources ignored during dummy period
    do_halt();
    pin_in[2] = 1'b0;
    for (int i = 0; i < 10 && !sys_clk_en; i++) @(negedge clk);
    halt_req = 1'b1; wdt_ovf = 1'b1; irq_req = 4'b0010;
    @(negedge clk);
    halt_req = 1'b0; wdt_ovf = 1'b0;
    wait_wake("R11 ignored", 2, 1, 0);
    irq_req = '0;
    pin_in = '1;
    idle(5);
    chk("R11 no new halt", cpu_hold, 0);

    // R12: external reset during halt
    do_halt();
    idle(3);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(2);
    chk("R12 pdf", pdf, 0);
    chk("R12 to", to, 0);
    chk("R12 clk_en", sys_clk_en, 1);
    chk("R12 hold", cpu_hold, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule